// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the integer registers of a 32-bit load/store processor. Software always sees sixteen logical registers, fifteen general ones plus the program counter at index 15. Which physical register answers a logical index depends on the current processor mode. Indices 0 to 7 and the program counter have one copy that every mode shares. Indices 8 to 12 switch to a private set only while the fast-interrupt mode is active. The stack pointer (13) and the link register (14) have one copy for each of the five exception modes, and User and System share a sixth copy.

The pipeline reads two operands and writes one result per cycle. A separate link port drops a return address into the current mode's register 14. A privileged-only side port reaches the user-bank copies of any index, so an operating system can save or restore a task's registers from an exception handler. Each exception mode also owns a saved status word. Software reads and writes it through its own port, and an exception-entry strobe captures the current status word into the copy that belongs to the mode being entered.

Top module: `banked_regfile`

## Requirements
- R1: Mode codes are User 10000, Fast-interrupt 10001, Interrupt 10010, Supervisor 10011, Abort 10111, Undefined 11011 and System 11111. Any other code selects the user bank and counts as unprivileged.
- R2: Logical registers 0 to 7 have one physical copy, and all modes read and write the same value.
- R3: Logical registers 8 to 12 use a private set in fast-interrupt mode only. All other modes share a common set.
- R4: Logical registers 13 and 14 have a private copy per exception mode. User and System share one copy.
- R5: Logical register 15 has one copy, shared by all modes.
- R6: Read ports are combinational. A write becomes visible after the next rising clock edge, so a read of the register being written in the same cycle returns the old value.
- R7: When several writes hit one physical register in the same cycle, the link write wins over the general write, and the general write wins over the user-bank port write.
- R8: A link write stores link_addr into register 14 of the current mode's bank.
- R9: In a privileged mode the user-bank port reads and writes the user-bank copy of usr_idx. In User mode (or with an unknown code) it reads zero, raises usr_err and ignores the write.
- R10: In an exception mode the status port reads and writes that mode's saved status word. In User or System mode it reads zero, raises sps_err and ignores the write.
- R11: An exception-entry strobe copies stat_cur into the saved status word of exc_mode. A non-exception exc_mode is ignored. In the same cycle, entry capture beats a software write to the same copy.
- R12: Reset clears every register and saved status word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current processor mode code |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data B |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write logical index |
| wr_data | input | 32 | General write data |
| link_we | input | 1 | Link-register write strobe |
| link_addr | input | 32 | Return address to store |
| usr_en | input | 1 | User-bank port access |
| usr_we | input | 1 | User-bank port write qualifier |
| usr_idx | input | 4 | User-bank logical index |
| usr_wdata | input | 32 | User-bank write data |
| usr_rdata | output | 32 | User-bank read data |
| usr_err | output | 1 | User-bank access refused |
| stat_cur | input | 32 | Current status word |
| exc_entry | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Mode being entered |
| sps_en | input | 1 | Saved-status port access |
| sps_we | input | 1 | Saved-status write qualifier |
| sps_wdata | input | 32 | Saved-status write data |
| sps_rdata | output | 32 | Saved-status read data |
| sps_err | output | 1 | Saved-status access refused |

## Verification
Read data, usr_err and sps_err are combinational, so they are due in the same cycle as the index and mode that select them. Register writes, link writes and exception captures show up one rising edge after the strobe. The bench drives every input on the falling edge and queues each expected value. The monitor compares it one nanosecond later, before the next rising edge. A write is therefore always checked in the low phase that follows its edge, and the same-cycle read of R6 is sampled before that edge.

// File: rtl/bank_pkg.sv
package bank_pkg;

  localparam int MODE_W  = 5;
  localparam int IDX_W   = 4;
  localparam int NBANK   = 6;
  localparam int NCOMMON = 13;
  localparam int NFIQ    = 5;
  localparam int NSTACK  = 2 * NBANK;
  localparam int NPHYS   = NCOMMON + NFIQ + NSTACK + 1;
  localparam int PH_W    = $clog2(NPHYS);
  localparam int NSAVE   = NBANK - 1;
  localparam int FIQ_BASE = NCOMMON;
  localparam int SL_BASE  = NCOMMON + NFIQ;
  localparam int PC_SLOT  = NPHYS - 1;

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  // Logical index plus bank -> physical slot number
  function automatic logic [PH_W-1:0] phys_of(logic [IDX_W-1:0] idx, bank_e bk);
    int i;
    i = int'(idx);
    if (i < 8)       return PH_W'(i);
    else if (i < 13) return (bk == BK_FIQ) ? PH_W'(FIQ_BASE + i - 8) : PH_W'(i);
    else if (i < 15) return PH_W'(SL_BASE + 2 * int'(bk) + i - 13);
    else             return PH_W'(PC_SLOT);
  endfunction

endpackage

// File: rtl/mode_decode.sv
module mode_decode
  import bank_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output bank_e             bank,
  output logic              saved_ok
);
  always_comb begin
    bank     = BK_USR;
    saved_ok = 1'b0;
    case (mode)
      M_FIQ: begin bank = BK_FIQ; saved_ok = 1'b1; end
      M_IRQ: begin bank = BK_IRQ; saved_ok = 1'b1; end
      M_SVC: begin bank = BK_SVC; saved_ok = 1'b1; end
      M_ABT: begin bank = BK_ABT; saved_ok = 1'b1; end
      M_UND: begin bank = BK_UND; saved_ok = 1'b1; end
      default: begin bank = BK_USR; saved_ok = 1'b0; end
    endcase
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import bank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lo_we,
  input  logic [PH_W-1:0] lo_sel,
  input  logic [DW-1:0]   lo_data,
  input  logic            mid_we,
  input  logic [PH_W-1:0] mid_sel,
  input  logic [DW-1:0]   mid_data,
  input  logic            hi_we,
  input  logic [PH_W-1:0] hi_sel,
  input  logic [DW-1:0]   hi_data,
  input  logic [PH_W-1:0] ra_sel,
  output logic [DW-1:0]   ra_data,
  input  logic [PH_W-1:0] rb_sel,
  output logic [DW-1:0]   rb_data,
  input  logic [PH_W-1:0] rc_sel,
  output logic [DW-1:0]   rc_data
);
  logic [NPHYS-1:0][DW-1:0] slot_q;

  for (genvar g = 0; g < NPHYS; g++) begin : g_slot
    logic          en;
    logic [DW-1:0] nx;
    logic [DW-1:0] q;

    // Later assignment wins: hi over mid over lo
    always_comb begin
      en = 1'b0;
      nx = q;
      if (lo_we  && lo_sel  == PH_W'(g)) begin en = 1'b1; nx = lo_data;  end
      if (mid_we && mid_sel == PH_W'(g)) begin en = 1'b1; nx = mid_data; end
      if (hi_we  && hi_sel  == PH_W'(g)) begin en = 1'b1; nx = hi_data;  end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= nx;
    end

    assign slot_q[g] = q;
  end

  assign ra_data = slot_q[ra_sel];
  assign rb_data = slot_q[rb_sel];
  assign rc_data = slot_q[rc_sel];
endmodule

// File: rtl/psr_save.sv
module psr_save
  import bank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  bank_e         cap_bank,
  input  logic [DW-1:0] cap_data,
  input  logic          sw_en,
  input  bank_e         sw_bank,
  input  logic [DW-1:0] sw_data,
  input  bank_e         rd_bank,
  output logic [DW-1:0] rd_data
);
  localparam int SW = $clog2(NSAVE + 1);

  logic [NSAVE-1:0][DW-1:0] save_q;
  logic [SW-1:0] cap_slot, sw_slot, rd_slot;

  assign cap_slot = SW'(cap_bank) - SW'(1);
  assign sw_slot  = SW'(sw_bank)  - SW'(1);
  assign rd_slot  = SW'(rd_bank)  - SW'(1);

  for (genvar s = 0; s < NSAVE; s++) begin : g_save
    logic          en;
    logic [DW-1:0] nx;
    logic [DW-1:0] q;

    always_comb begin
      en = 1'b0;
      nx = q;
      if (sw_en  && sw_slot  == SW'(s)) begin en = 1'b1; nx = sw_data;  end
      if (cap_en && cap_slot == SW'(s)) begin en = 1'b1; nx = cap_data; end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= nx;
    end

    assign save_q[s] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NSAVE; k++)
      if (rd_slot == SW'(k)) rd_data = save_q[k];
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DW-1:0]     rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DW-1:0]     rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic              link_we,
  input  logic [DW-1:0]     link_addr,
  input  logic              usr_en,
  input  logic              usr_we,
  input  logic [IDX_W-1:0]  usr_idx,
  input  logic [DW-1:0]     usr_wdata,
  output logic [DW-1:0]     usr_rdata,
  output logic              usr_err,
  input  logic [DW-1:0]     stat_cur,
  input  logic              exc_entry,
  input  logic [MODE_W-1:0] exc_mode,
  input  logic              sps_en,
  input  logic              sps_we,
  input  logic [DW-1:0]     sps_wdata,
  output logic [DW-1:0]     sps_rdata,
  output logic              sps_err
);
  localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(14);

  // Asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  bank_e cur_bank, exc_bank;
  logic  cur_sav, exc_sav, cur_priv;

  mode_decode u_cur (.mode(mode_i),   .bank(cur_bank), .saved_ok(cur_sav));
  mode_decode u_exc (.mode(exc_mode), .bank(exc_bank), .saved_ok(exc_sav));

  assign cur_priv = cur_sav | (mode_i == M_SYS);

  logic [PH_W-1:0] ra_p, rb_p, wr_p, lk_p, us_p;
  assign ra_p = phys_of(rd_a_idx, cur_bank);
  assign rb_p = phys_of(rd_b_idx, cur_bank);
  assign wr_p = phys_of(wr_idx,   cur_bank);
  assign lk_p = phys_of(LINK_IDX, cur_bank);
  assign us_p = phys_of(usr_idx,  BK_USR);

  logic          usr_ok, usr_wr_ok;
  logic [DW-1:0] usr_raw;
  assign usr_ok    = usr_en & cur_priv;
  assign usr_wr_ok = usr_ok & usr_we;

  gpr_bank #(.DW(DW)) u_gpr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .lo_we    (usr_wr_ok),
    .lo_sel   (us_p),
    .lo_data  (usr_wdata),
    .mid_we   (wr_en),
    .mid_sel  (wr_p),
    .mid_data (wr_data),
    .hi_we    (link_we),
    .hi_sel   (lk_p),
    .hi_data  (link_addr),
    .ra_sel   (ra_p),
    .ra_data  (rd_a_data),
    .rb_sel   (rb_p),
    .rb_data  (rd_b_data),
    .rc_sel   (us_p),
    .rc_data  (usr_raw)
  );

  assign usr_rdata = usr_ok ? usr_raw : '0;
  assign usr_err   = usr_en & ~cur_priv;

  logic          sps_ok;
  logic [DW-1:0] sps_raw;
  assign sps_ok = sps_en & cur_sav;

  psr_save #(.DW(DW)) u_psr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cap_en   (exc_entry & exc_sav),
    .cap_bank (exc_bank),
    .cap_data (stat_cur),
    .sw_en    (sps_ok & sps_we),
    .sw_bank  (cur_bank),
    .sw_data  (sps_wdata),
    .rd_bank  (cur_bank),
    .rd_data  (sps_raw)
  );

  assign sps_rdata = sps_ok ? sps_raw : '0;
  assign sps_err   = sps_en & ~cur_sav;
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import bank_pkg::*;
#(
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_i,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DW-1:0]     rd_a_data,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DW-1:0]     wr_data,
  input logic              link_we,
  input logic [DW-1:0]     link_addr,
  input logic              usr_en,
  input logic              usr_we,
  input logic [DW-1:0]     usr_rdata,
  input logic              usr_err,
  input logic [DW-1:0]     stat_cur,
  input logic              exc_entry,
  input logic [MODE_W-1:0] exc_mode,
  input logic              sps_en,
  input logic [DW-1:0]     sps_rdata,
  input logic              sps_err
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  function automatic logic exc_code(logic [MODE_W-1:0] m);
    return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
           (m == M_ABT) || (m == M_UND);
  endfunction

  // R5: one program counter, whatever the mode on the next cycle
  a_r5_pc_shared: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(wr_en && wr_idx == 4'd15) && rd_a_idx == 4'd15
      |-> rd_a_data == $past(wr_data));

  // R8: link write lands in current mode's register 14
  a_r8_link_capture: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(link_we) && mode_i == $past(mode_i) && rd_a_idx == 4'd14
      |-> rd_a_data == $past(link_addr));

  // R9: user-bank port refused in User mode
  a_r9_user_refused: assert property (@(posedge clk) disable iff (!rst_n)
    usr_en && mode_i == M_USR |-> usr_err && usr_rdata == '0);

  // R9: refused user-bank write leaves registers unchanged
  a_r9_user_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(usr_en && usr_we && mode_i == M_USR && !wr_en && !link_we)
      && $stable(mode_i) && $stable(rd_a_idx) |-> $stable(rd_a_data));

  // R10: saved status port refused outside exception modes
  a_r10_status_refused: assert property (@(posedge clk) disable iff (!rst_n)
    sps_en && (mode_i == M_USR || mode_i == M_SYS) |-> sps_err && sps_rdata == '0);

  // R11: entry capture readable in the entered mode one cycle later
  a_r11_entry_capture: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(exc_entry && exc_mode == mode_i) && mode_i == $past(mode_i)
      && sps_en && exc_code(mode_i) |-> sps_rdata == $past(stat_cur));
endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .rd_a_idx  (rd_a_idx),
  .rd_a_data (rd_a_data),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .link_we   (link_we),
  .link_addr (link_addr),
  .usr_en    (usr_en),
  .usr_we    (usr_we),
  .usr_rdata (usr_rdata),
  .usr_err   (usr_err),
  .stat_cur  (stat_cur),
  .exc_entry (exc_entry),
  .exc_mode  (exc_mode),
  .sps_en    (sps_en),
  .sps_rdata (sps_rdata),
  .sps_err   (sps_err)
);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
  import bank_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  mode_i;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx, usr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, link_addr, usr_wdata, usr_rdata;
  logic [31:0] stat_cur, sps_wdata, sps_rdata;
  logic        wr_en, link_we, usr_en, usr_we, usr_err, exc_entry, sps_en, sps_we, sps_err;
  logic [4:0]  exc_mode;

  always #2.5 clk = ~clk;

  banked_regfile u_dut (.*);

  localparam int K_RA = 0, K_RB = 1, K_UD = 2, K_UE = 3, K_SD = 4, K_SE = 5;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  function automatic logic [31:0] pick(int k);
    case (k)
      K_RA:    return rd_a_data;
      K_RB:    return rd_b_data;
      K_UD:    return usr_rdata;
      K_UE:    return {31'b0, usr_err};
      K_SD:    return sps_rdata;
      default: return {31'b0, sps_err};
    endcase
  endfunction

  // Monitor: compare queued items 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        logic [31:0] got;
        e = sb_q.pop_front();
        got = pick(e.kind);
        n_cmp++;
        if (got !== e.exp) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", e.tag, got, e.exp);
        end
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic expect_v(int kind, logic [3:0] idx, logic [31:0] exp, string tag);
    exp_t e;
    case (kind)
      K_RA:       rd_a_idx = idx;
      K_RB:       rd_b_idx = idx;
      K_UD, K_UE: usr_idx  = idx;
      default:    ;
    endcase
    e.kind = kind; e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    cyc();
  endtask

  task automatic wr_reg(logic [3:0] idx, logic [31:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1'b1;
      report();
    end
  end

  initial begin
    rst_n = 1'b0; mode_i = M_USR;
    rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; usr_idx = '0;
    wr_data = '0; link_addr = '0; usr_wdata = '0; stat_cur = '0; sps_wdata = '0;
    wr_en = 0; link_we = 0; usr_en = 0; usr_we = 0; exc_entry = 0; sps_en = 0; sps_we = 0;
    exc_mode = M_USR;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R12: everything cleared
    expect_v(K_RA, 4'd5, 32'h0, "R12 reg5");
    expect_v(K_RB, 4'd15, 32'h0, "R12 pc");
    mode_i = M_IRQ; sps_en = 1'b1;
    expect_v(K_SD, 4'd0, 32'h0, "R12 saved status");
    sps_en = 1'b0;

    // Fill user view
    mode_i = M_USR;
    for (int i = 0; i < 16; i++) wr_reg(4'(i), 32'h100 + i);

    mode_i = M_FIQ;
    expect_v(K_RA, 4'd3, 32'h103, "R2 low reg shared");
    expect_v(K_RA, 4'd9, 32'h0, "R3 fiq private set");
    expect_v(K_RB, 4'd13, 32'h0, "R4 fiq sp");
    expect_v(K_RA, 4'd15, 32'h10f, "R5 pc shared");
    wr_reg(4'd9, 32'hF9);
    wr_reg(4'd13, 32'hFD);
    wr_reg(4'd2, 32'h2F);
    mode_i = M_USR;
    expect_v(K_RA, 4'd9, 32'h109, "R3 common set kept");
    expect_v(K_RA, 4'd13, 32'h10d, "R4 user sp kept");
    expect_v(K_RB, 4'd2, 32'h2F, "R2 write in fiq seen in user");
    mode_i = M_FIQ;
    expect_v(K_RA, 4'd9, 32'hF9, "R3 fiq set kept");
    mode_i = M_SYS;
    expect_v(K_RA, 4'd13, 32'h10d, "R4 system shares user sp");
    expect_v(K_RB, 4'd9, 32'h109, "R3 system uses common set");
    mode_i = M_IRQ;
    expect_v(K_RA, 4'd13, 32'h0, "R4 irq sp");
    wr_reg(4'd13, 32'h1D);
    mode_i = M_SVC;
    expect_v(K_RA, 4'd13, 32'h0, "R4 svc sp separate");
    mode_i = M_IRQ;
    expect_v(K_RA, 4'd13, 32'h1D, "R4 irq sp kept");

    // R1: unknown code acts as User
    mode_i = 5'b00101;
    expect_v(K_RA, 4'd13, 32'h10d, "R1 unknown uses user bank");
    usr_en = 1'b1;
    expect_v(K_UE, 4'd0, 32'h1, "R1 unknown unprivileged");
    usr_en = 1'b0;

    // R6: same-cycle read returns old value
    mode_i = M_USR;
    wr_en = 1'b1; wr_idx = 4'd4; wr_data = 32'h444;
    expect_v(K_RA, 4'd4, 32'h104, "R6 old value in write cycle");
    wr_en = 1'b0;
    expect_v(K_RA, 4'd4, 32'h444, "R6 new value after edge");

    // R7: priority
    mode_i = M_SVC;
    wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'hAAAA;
    link_we = 1'b1; link_addr = 32'hBBBB;
    cyc();
    wr_en = 1'b0; link_we = 1'b0;
    expect_v(K_RA, 4'd14, 32'hBBBB, "R7 link beats general");
    mode_i = M_SYS;
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h333;
    usr_en = 1'b1; usr_we = 1'b1; usr_idx = 4'd3; usr_wdata = 32'h3E3;
    cyc();
    wr_en = 1'b0; usr_en = 1'b0; usr_we = 1'b0;
    expect_v(K_RA, 4'd3, 32'h333, "R7 general beats user port");

    // R8: link write into current bank
    mode_i = M_IRQ;
    link_we = 1'b1; link_addr = 32'hC0DE;
    cyc();
    link_we = 1'b0;
    expect_v(K_RA, 4'd14, 32'hC0DE, "R8 irq link");
    mode_i = M_USR;
    expect_v(K_RA, 4'd14, 32'h10e, "R8 user link untouched");

    // R9: user-bank port
    mode_i = M_SVC; usr_en = 1'b1;
    expect_v(K_UD, 4'd13, 32'h10d, "R9 privileged read user sp");
    expect_v(K_UE, 4'd13, 32'h0, "R9 no error when privileged");
    usr_we = 1'b1; usr_idx = 4'd9; usr_wdata = 32'h999;
    cyc();
    usr_we = 1'b0; usr_en = 1'b0;
    mode_i = M_USR;
    expect_v(K_RA, 4'd9, 32'h999, "R9 privileged write user reg9");
    mode_i = M_FIQ;
    expect_v(K_RA, 4'd9, 32'hF9, "R9 fiq reg9 untouched");
    mode_i = M_USR; usr_en = 1'b1;
    expect_v(K_UD, 4'd0, 32'h0, "R9 user-mode read zero");
    expect_v(K_UE, 4'd0, 32'h1, "R9 user-mode error");
    usr_we = 1'b1; usr_wdata = 32'hDEAD;
    cyc();
    usr_we = 1'b0; usr_en = 1'b0;
    expect_v(K_RA, 4'd0, 32'h100, "R9 user-mode write ignored");

    // R11 / R10: saved status
    stat_cur = 32'hA5; exc_mode = M_IRQ; exc_entry = 1'b1;
    cyc();
    exc_entry = 1'b0;
    mode_i = M_IRQ; sps_en = 1'b1;
    expect_v(K_SD, 4'd0, 32'hA5, "R11 entry captured for irq");
    expect_v(K_SE, 4'd0, 32'h0, "R10 no error in exception mode");
    sps_we = 1'b1; sps_wdata = 32'h77;
    cyc();
    sps_we = 1'b0;
    expect_v(K_SD, 4'd0, 32'h77, "R10 software write");
    mode_i = M_ABT;
    expect_v(K_SD, 4'd0, 32'h0, "R10 abort copy separate");
    mode_i = M_USR;
    expect_v(K_SD, 4'd0, 32'h0, "R10 user reads zero");
    expect_v(K_SE, 4'd0, 32'h1, "R10 user error");
    sps_we = 1'b1; sps_wdata = 32'h55;
    cyc();
    sps_we = 1'b0;
    mode_i = M_SYS;
    expect_v(K_SE, 4'd0, 32'h1, "R10 system error");
    stat_cur = 32'h66; exc_mode = M_SYS; exc_entry = 1'b1;
    cyc();
    exc_entry = 1'b0;
    mode_i = M_IRQ;
    expect_v(K_SD, 4'd0, 32'h77, "R10 R11 irq copy unchanged");
    mode_i = M_UND;
    expect_v(K_SD, 4'd0, 32'h0, "R11 non-exception entry ignored");
    sps_we = 1'b1; sps_wdata = 32'h11;
    stat_cur = 32'h22; exc_mode = M_UND; exc_entry = 1'b1;
    cyc();
    sps_we = 1'b0; exc_entry = 1'b0;
    expect_v(K_SD, 4'd0, 32'h22, "R11 entry beats software write");
    sps_en = 1'b0;

    repeat (2) cyc();
    if (!done) begin
      done = 1'b1;
      report();
    end
  end
endmodule